// File: doc/BRIEF.md
# Hiccup-Mode Fault Protection Controller

This controller sequences a switching regulator through start-up and watches two fault conditions while the regulator runs. One condition is an output that sags too low. The other is a load current above a limit that scales with how many power stages are fitted. Each condition has its own 3-bit persistence counter, so a short glitch does not stop the regulator. A condition that lasts long enough does stop it. The controller then holds the regulator off for a cool-down. The cool-down is as long as the soft-start. After the cool-down it starts again on its own, and this repeats for as long as the fault is there.

The sensing front end gives the controller one strobe per switching cycle. With the strobe come a feedback code, a current code and a reference code. The stage count and the interval length are static settings. The controller drives a run enable, a soft-start window flag and a one-cycle done pulse. These go to the soft-start ramp generator and the PWM logic. It also drives a flag that is high during a fault cool-down.

Top module: `hiccup_guard`

## Requirements
- R1: While reset is asserted, and in the idle state, `reg_run`, `ss_active`, `ss_done` and `shutdown` are all 0.
- R2: When `enable` is high in the idle state, the next clock enters soft-start. `ss_active` and `reg_run` are then high for exactly `interval_len` cycles (`interval_len` ≥ 1). The block then enters run, with `ss_done` high for that one cycle only.
- R3: The current limit is `stage_count` × `STAGE_LIMIT` (default 64 codes per stage). Only a sample with `cur_code` strictly above the limit counts as over-current.
- R4: An over-current sample raises the over-current counter by one. A valid sample at or under the limit clears it. The sample that brings the count to 7 (binary 111) shuts the regulator down.
- R5: A sample is under-voltage when `fb_code`·200 < `ref_code`·178 (89 %). Each such sample raises a separate counter. The regulator shuts down when this counter overflows, which is on the 8th counted sample.
- R6: The under-voltage counter clears only on a sample with `fb_code`·40 > `ref_code`·37 (above 92.5 %). Samples between the two levels leave the counter unchanged.
- R7: On shutdown, `reg_run` and `ss_active` drop and `shutdown` is high for exactly `interval_len` cycles. Both counters start from zero. Soft-start then begins again without any outside action.
- R8: Faults are counted during soft-start as well as in run. A shutdown that falls on the last soft-start cycle takes priority: no `ss_done` and no run. The retry loop has no limit.
- R9: When `enable` is low, the block returns to idle on the next clock from any state, and clears both counters and the interval timer.
- R10: Codes presented while `sample_valid` is low have no effect on either counter. Samples taken during cool-down or idle are also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Regulator enable request |
| sample_valid | input | 1 | One strobe per switching cycle; codes are valid |
| fb_code | input | CODE_W | Sampled feedback code |
| cur_code | input | CUR_W | Sampled current code |
| ref_code | input | CODE_W | Reference code |
| stage_count | input | STG_W | Number of connected power stages |
| interval_len | input | TIME_W | Soft-start and cool-down length in cycles |
| reg_run | output | 1 | Regulator allowed to switch |
| ss_active | output | 1 | Soft-start window open |
| ss_done | output | 1 | One-cycle pulse on soft-start completion |
| shutdown | output | 1 | Fault cool-down in progress |

## Verification
Two events can land on the same clock edge: the last cycle of soft-start and the sample that saturates a fault counter. The bench sets up this overlap on purpose. It starts a soft-start, waits three quiet cycles, and then sends over-current samples. The seventh one arrives exactly on the final soft-start edge. The correct result is that `shutdown` rises and `ss_done` stays low. An enable drop in the middle of a fault count is also tried, to show that nothing carries over into the next start.

// File: rtl/hiccup_guard.sv
module hiccup_guard #(
  parameter int CODE_W      = 12,
  parameter int CUR_W       = 12,
  parameter int STG_W       = 3,
  parameter int TIME_W      = 16,
  parameter int STAGE_LIMIT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              sample_valid,
  input  logic [CODE_W-1:0] fb_code,
  input  logic [CUR_W-1:0]  cur_code,
  input  logic [CODE_W-1:0] ref_code,
  input  logic [STG_W-1:0]  stage_count,
  input  logic [TIME_W-1:0] interval_len,
  output logic              reg_run,
  output logic              ss_active,
  output logic              ss_done,
  output logic              shutdown
);

  localparam int LIM_W = STG_W + $clog2(STAGE_LIMIT + 1);
  localparam int CMP_W = ((LIM_W > CUR_W) ? LIM_W : CUR_W) + 1;
  localparam int FB_W  = CODE_W + 8;

  typedef enum logic [1:0] {S_OFF, S_SS, S_RUN, S_COOL} state_t;

  state_t            state;
  logic [2:0]        oc_cnt, uv_cnt;
  logic [TIME_W-1:0] timer;

  logic [CMP_W-1:0] oc_limit;
  logic [FB_W-1:0]  fb_x200, ref_x178, fb_x40, ref_x37;
  logic             oc_over, uv_low, uv_clear;
  logic             powered, oc_hit, uv_hit, trip, timer_end;
  logic [TIME_W:0]  timer_nx;

  assign oc_limit = CMP_W'(stage_count) * CMP_W'(STAGE_LIMIT);
  assign oc_over  = CMP_W'(cur_code) > oc_limit;

  assign fb_x200  = FB_W'(fb_code)  * FB_W'(200);
  assign ref_x178 = FB_W'(ref_code) * FB_W'(178);
  assign fb_x40   = FB_W'(fb_code)  * FB_W'(40);
  assign ref_x37  = FB_W'(ref_code) * FB_W'(37);
  assign uv_low   = fb_x200 < ref_x178;
  assign uv_clear = fb_x40 > ref_x37;

  assign powered   = (state == S_SS) || (state == S_RUN);
  assign oc_hit    = powered && sample_valid && oc_over;
  assign uv_hit    = powered && sample_valid && uv_low;
  assign trip      = (oc_hit && oc_cnt == 3'd6) || (uv_hit && uv_cnt == 3'd7);
  assign timer_nx  = {1'b0, timer} + 1'b1;
  assign timer_end = timer_nx >= {1'b0, interval_len};

  assign reg_run   = powered;
  assign ss_active = (state == S_SS);
  assign shutdown  = (state == S_COOL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_OFF;
      oc_cnt  <= '0;
      uv_cnt  <= '0;
      timer   <= '0;
      ss_done <= 1'b0;
    end else begin
      ss_done <= 1'b0;
      if (!enable) begin
        state  <= S_OFF;
        oc_cnt <= '0;
        uv_cnt <= '0;
        timer  <= '0;
      end else begin
        case (state)
          S_OFF: begin
            state <= S_SS;
            timer <= '0;
          end
          S_SS, S_RUN: begin
            if (trip) begin
              state  <= S_COOL;
              oc_cnt <= '0;
              uv_cnt <= '0;
              timer  <= '0;
            end else begin
              if (sample_valid) begin
                oc_cnt <= oc_over ? oc_cnt + 3'd1 : 3'd0;
                if (uv_low)        uv_cnt <= uv_cnt + 3'd1;
                else if (uv_clear) uv_cnt <= 3'd0;
              end
              if (state == S_SS) begin
                if (timer_end) begin
                  state   <= S_RUN;
                  ss_done <= 1'b1;
                  timer   <= '0;
                end else begin
                  timer <= timer_nx[TIME_W-1:0];
                end
              end
            end
          end
          default: begin
            if (timer_end) begin
              state <= S_SS;
              timer <= '0;
            end else begin
              timer <= timer_nx[TIME_W-1:0];
            end
          end
        endcase
      end
    end
  end

  // R2: completion pulse lasts one cycle and only follows soft-start
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |=> !ss_done);
  p_done_from_ss_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> $past(ss_active) && reg_run);

  // R4: a valid in-limit sample leaves the over-current count at zero
  p_oc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && sample_valid && !oc_over) |=> oc_cnt == 3'd0);

  // R7: cool-down is entered only from a powered state
  p_cool_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown) |-> $past(reg_run));

  // R9: enable low forces idle with a cleared timer
  p_disable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (state == S_OFF) && timer == '0 && oc_cnt == 3'd0);

  // R10: counters do not move without a strobe
  p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !sample_valid) |=> $stable(oc_cnt) && $stable(uv_cnt));

endmodule

// File: tb/hiccup_guard_bench.sv
module hiccup_guard_bench;
  localparam int L = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic sample_valid = 1'b0;
  logic [11:0] fb_code = 12'd1000;
  logic [11:0] cur_code = '0;
  logic [11:0] ref_code = 12'd1000;
  logic [2:0]  stage_count = 3'd3;
  logic [15:0] interval_len = 16'(L);
  logic reg_run, ss_active, ss_done, shutdown;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  hiccup_guard u_hiccup_guard (
    .clk(clk), .rst_n(rst_n), .enable(enable), .sample_valid(sample_valid),
    .fb_code(fb_code), .cur_code(cur_code), .ref_code(ref_code),
    .stage_count(stage_count), .interval_len(interval_len),
    .reg_run(reg_run), .ss_active(ss_active), .ss_done(ss_done),
    .shutdown(shutdown)
  );

  task automatic step(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic outs(input string req, input string what,
                      input int run, input int ss, input int done, input int sd);
    chk(req, {what, " reg_run"}, int'(reg_run), run);
    chk(req, {what, " ss_active"}, int'(ss_active), ss);
    chk(req, {what, " ss_done"}, int'(ss_done), done);
    chk(req, {what, " shutdown"}, int'(shutdown), sd);
  endtask

  task automatic go_off();
    enable = 1'b0;
    sample_valid = 1'b0;
    cur_code = '0;
    fb_code = 12'd1000;
    ref_code = 12'd1000;
    stage_count = 3'd3;
    step();
  endtask

  task automatic start_run(input string req);
    enable = 1'b1;
    step();
    outs(req, "ss entry", 1, 1, 0, 0);
    step(L - 1);
    outs(req, "ss last", 1, 1, 0, 0);
    step();
    outs(req, "run entry", 1, 0, 1, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(2);
    outs("R1", "in reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    step(3);
    outs("R1", "idle", 0, 0, 0, 0);
  endtask

  task automatic t_startup();
    go_off();
    start_run("R2");
    step();
    outs("R2", "after pulse", 1, 0, 0, 0);
  endtask

  task automatic t_overcurrent();
    go_off();
    start_run("R2");
    sample_valid = 1'b1;
    cur_code = 12'd192;
    step(10);
    chk("R3", "at limit no trip", int'(shutdown), 0);
    cur_code = 12'd193;
    step(6);
    chk("R4", "six over", int'(shutdown), 0);
    cur_code = 12'd192;
    step();
    cur_code = 12'd193;
    step(6);
    chk("R4", "count cleared by in-limit", int'(shutdown), 0);
    step();
    outs("R4", "seventh over", 0, 0, 0, 1);
    step(L - 1);
    outs("R7", "cooldown last", 0, 0, 0, 1);
    step();
    outs("R7", "retry ss", 1, 1, 0, 0);
    step(6);
    chk("R8", "six over in ss", int'(shutdown), 0);
    step();
    outs("R8", "trip in ss", 0, 0, 0, 1);
    cur_code = '0;
    step(L);
    step(L);
    outs("R8", "recovered", 1, 0, 1, 0);
  endtask

  task automatic t_stage_scale();
    go_off();
    stage_count = 3'd1;
    start_run("R2");
    sample_valid = 1'b1;
    cur_code = 12'd64;
    step(9);
    chk("R3", "one stage at 64", int'(shutdown), 0);
    cur_code = 12'd65;
    step(6);
    chk("R3", "one stage six over", int'(shutdown), 0);
    step();
    chk("R3", "one stage trip", int'(shutdown), 1);
  endtask

  task automatic t_undervolt();
    go_off();
    start_run("R2");
    sample_valid = 1'b1;
    fb_code = 12'd890;
    step(12);
    chk("R5", "fb 890 not under", int'(shutdown), 0);
    fb_code = 12'd926;
    step();
    fb_code = 12'd889;
    step(7);
    chk("R5", "seven under", int'(shutdown), 0);
    step();
    chk("R5", "eighth under", int'(shutdown), 1);

    go_off();
    start_run("R2");
    sample_valid = 1'b1;
    fb_code = 12'd889;
    step(5);
    fb_code = 12'd925;
    step();
    fb_code = 12'd900;
    step();
    fb_code = 12'd889;
    step(2);
    chk("R6", "band holds count", int'(shutdown), 0);
    step();
    chk("R6", "band hold trips", int'(shutdown), 1);

    go_off();
    start_run("R2");
    sample_valid = 1'b1;
    fb_code = 12'd889;
    step(5);
    fb_code = 12'd926;
    step();
    fb_code = 12'd889;
    step(7);
    chk("R6", "926 clears count", int'(shutdown), 0);
    step();
    chk("R6", "fresh eight", int'(shutdown), 1);
  endtask

  task automatic t_no_strobe();
    go_off();
    start_run("R2");
    sample_valid = 1'b0;
    cur_code = 12'd4000;
    fb_code = 12'd0;
    step(20);
    outs("R10", "no strobe", 1, 0, 0, 0);
    fb_code = 12'd1000;
    sample_valid = 1'b1;
    step(6);
    chk("R10", "count began at zero", int'(shutdown), 0);
    step();
    chk("R10", "trip after seven", int'(shutdown), 1);
  endtask

  task automatic t_enable_drop();
    go_off();
    start_run("R2");
    sample_valid = 1'b1;
    cur_code = 12'd500;
    step(5);
    enable = 1'b0;
    step();
    outs("R9", "run dropped", 0, 0, 0, 0);
    sample_valid = 1'b0;
    cur_code = '0;
    enable = 1'b1;
    step(4);
    enable = 1'b0;
    step();
    outs("R9", "ss dropped", 0, 0, 0, 0);
    start_run("R9");
    sample_valid = 1'b1;
    cur_code = 12'd500;
    step(6);
    chk("R9", "counter cleared", int'(shutdown), 0);
    step();
    chk("R9", "fresh trip", int'(shutdown), 1);
    step(3);
    enable = 1'b0;
    step();
    outs("R9", "cool dropped", 0, 0, 0, 0);
  endtask

  task automatic t_collide();
    go_off();
    enable = 1'b1;
    step();
    outs("R8", "ss entry", 1, 1, 0, 0);
    step(3);
    sample_valid = 1'b1;
    cur_code = 12'd500;
    step(7);
    outs("R8", "trip wins over done", 0, 0, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_startup();
    t_overcurrent();
    t_stage_scale();
    t_undervolt();
    t_no_strobe();
    t_enable_drop();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule